// File: doc/BRIEF.md
# Channel-Group Stream Flattener

This block sits between a convolution result stream and a fully connected engine. The convolution side delivers its data interleaved in small groups. First come four consecutive spatial elements of channel 0, then four of channel 1, then channels 2 and 3. After channel 3 the next four elements of channel 0 follow, and the pattern repeats. The fully connected engine wants a single row-major vector instead: every element of channel 0, then every element of channel 1, and so on.

The block reorders the stream in two phases. In the capture phase it accepts the whole frame. Each group of four goes into the storage bank for its channel, and each bank holds one channel. In the drain phase it reads the banks out one after another and emits the flattened vector. A one-cycle done pulse follows the last element.

The per-channel element count (rows times columns of the previous convolution output) is a configuration input. If that count is not a multiple of four, the last group of every channel is padded. The padded positions are stored and emitted as zero, whatever data arrived for them.

When the flatten flag is clear, for example after a previous fully connected layer, the stream passes straight through. Both streams are valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. While valid is high and ready is low, the sender holds its data. Configuration may change only between frames, while the block is waiting for the first element of a frame.

Top module: `chan_group_flattener`

## Requirements
- R1: After reset, with the flatten flag set, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: In flatten mode, accepted input element k (counting from 0 in the frame) belongs to channel (k/4) mod 4 at in-channel index (k/16)*4 + k mod 4. A frame has 4*P input elements, where P is `cfg_count` rounded up to a multiple of 4.
- R3: The drain emits P elements of bank 0 in index order, then P of bank 1, then bank 2, then bank 3. Each element equals the value captured for that channel and index.
- R4: Every position whose in-channel index is at least `cfg_count` is emitted as zero, whatever data was supplied for it.
- R5: In flatten mode, `out_valid` is 0 throughout capture, and `in_ready` is 0 throughout the drain.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged on the next cycle.
- R7: `done` is high for exactly one cycle, the cycle after the final drain transfer. In that cycle the block is already back in capture with `in_ready` at 1.
- R8: With the flatten flag clear, `out_valid` follows `in_valid`, `out_data` follows `in_data` and `in_ready` follows `out_ready` in the same cycle. `done` stays 0, and the capture position does not move.
- R9: `cfg_count` ranges from 1 to MAX_ELEMS. Gaps in `in_valid` during capture pause the frame without losing position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flatten_en | input | 1 | 1 = reorder, 0 = pass through |
| cfg_count | input | CNT_W (7) | Elements per channel (rows x cols) |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block accepts input |
| in_data | input | DATA_W (8) | Input element |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Consumer accepts output |
| out_data | output | DATA_W (8) | Output element |
| done | output | 1 | One-cycle pulse after frame drained |

## Verification
Capture has no visible output per element. Once the last input transfer completes, the drain starts on the very next cycle, so the bench expects `out_valid` within one edge. Drain data is combinational from the bank selected by the read position, so each output word is checked in the same cycle as its transfer, at mid-cycle before the next edge. Data held under back-pressure is compared against the word seen one cycle earlier. `done` is checked exactly one edge after the final output transfer and checked clear one edge later. Bypass results are combinational and are checked a short delay after the inputs change, with no clock edge in between.

// File: rtl/flat_pkg.sv
package flat_pkg;
  typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_t;
endpackage

// File: rtl/chan_bank.sv
module chan_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/chan_fill_seq.sv
module chan_fill_seq #(
  parameter int NUM_CH = 4,
  parameter int GRP    = 4,
  parameter int AW     = 6,
  parameter int CNT_W  = 7,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int GW    = $clog2(GRP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] pad_len,
  output logic [CHW-1:0]   wr_ch,
  output logic [AW-1:0]    wr_addr,
  output logic             last
);
  logic [GW-1:0] elem;
  logic [AW-1:0] grp_base;

  assign wr_addr = grp_base + AW'(elem);
  assign last    = (elem == GW'(GRP - 1)) && (wr_ch == CHW'(NUM_CH - 1)) &&
                   (CNT_W'(grp_base) + CNT_W'(GRP) == pad_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elem     <= '0;
      wr_ch    <= '0;
      grp_base <= '0;
    end else if (step) begin
      if (elem == GW'(GRP - 1)) begin
        elem <= '0;
        if (wr_ch == CHW'(NUM_CH - 1)) begin
          wr_ch    <= '0;
          grp_base <= last ? '0 : grp_base + AW'(GRP);
        end else begin
          wr_ch <= wr_ch + CHW'(1);
        end
      end else begin
        elem <= elem + GW'(1);
      end
    end
  end

  // R2: every write lands inside the padded channel length
  p_wr_in_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (CNT_W'(wr_addr) < pad_len));
  // R2: after a final write the capture position restarts at the origin
  p_fill_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (wr_addr == '0 && wr_ch == '0));
endmodule

// File: rtl/chan_drain_seq.sv
module chan_drain_seq #(
  parameter int NUM_CH = 4,
  parameter int AW     = 6,
  parameter int CNT_W  = 7,
  localparam int CHW   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] pad_len,
  output logic [CHW-1:0]   rd_ch,
  output logic [AW-1:0]    rd_addr,
  output logic             last
);
  logic bank_end;

  assign bank_end = (CNT_W'(rd_addr) + CNT_W'(1) == pad_len);
  assign last     = bank_end && (rd_ch == CHW'(NUM_CH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ch   <= '0;
      rd_addr <= '0;
    end else if (step) begin
      if (bank_end) begin
        rd_addr <= '0;
        rd_ch   <= last ? '0 : rd_ch + CHW'(1);
      end else begin
        rd_addr <= rd_addr + AW'(1);
      end
    end
  end

  // R3: a bank is left only at its final padded index
  p_bank_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !bank_end) |=> $stable(rd_ch));
endmodule

// File: rtl/chan_group_flattener.sv
module chan_group_flattener #(
  parameter int DATA_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int GRP       = 4,
  parameter int MAX_ELEMS = 64,
  localparam int AW       = $clog2(MAX_ELEMS),
  localparam int CNT_W    = $clog2(MAX_ELEMS + 1),
  localparam int CHW      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_flatten_en,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  import flat_pkg::*;

  phase_t            phase;
  logic [CNT_W-1:0]  pad_len;
  logic              fill_step, fill_last, drain_step, drain_last;
  logic [CHW-1:0]    wr_ch, rd_ch;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_bus [NUM_CH];

  assign pad_len = (cfg_count + CNT_W'(GRP - 1)) & ~CNT_W'(GRP - 1);

  assign fill_step  = cfg_flatten_en && (phase == PH_FILL) && in_valid;
  assign drain_step = cfg_flatten_en && (phase == PH_DRAIN) && out_ready;

  assign in_ready  = cfg_flatten_en ? (phase == PH_FILL)  : out_ready;
  assign out_valid = cfg_flatten_en ? (phase == PH_DRAIN) : in_valid;
  assign out_data  = cfg_flatten_en ? rd_bus[rd_ch]       : in_data;

  assign wr_data = (CNT_W'(wr_addr) >= cfg_count) ? '0 : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FILL;
      done  <= 1'b0;
    end else begin
      done <= drain_step && drain_last;
      if (fill_step && fill_last)   phase <= PH_DRAIN;
      if (drain_step && drain_last) phase <= PH_FILL;
    end
  end

  chan_fill_seq #(.NUM_CH(NUM_CH), .GRP(GRP), .AW(AW), .CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .step(fill_step), .pad_len(pad_len),
    .wr_ch(wr_ch), .wr_addr(wr_addr), .last(fill_last)
  );

  chan_drain_seq #(.NUM_CH(NUM_CH), .AW(AW), .CNT_W(CNT_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .step(drain_step), .pad_len(pad_len),
    .rd_ch(rd_ch), .rd_addr(rd_addr), .last(drain_last)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    chan_bank #(.DATA_W(DATA_W), .DEPTH(MAX_ELEMS)) u_bank (
      .clk(clk),
      .we(fill_step && (wr_ch == CHW'(c))),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(rd_addr),
      .rdata(rd_bus[c])
    );
  end

  // R5: no input is taken while the flattened vector is being emitted
  p_no_accept_in_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flatten_en && out_valid) |-> !in_ready);
  // R6: held output under back-pressure
  p_hold_under_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flatten_en && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R4: padded positions come out as zero
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flatten_en && out_valid && (CNT_W'(rd_addr) >= cfg_count)) |-> (out_data == '0));
  // R7: done is a single-cycle pulse following a completed output transfer
  p_done_follows_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) && in_ready));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_chan_group_flattener.sv
module tb_chan_group_flattener;
  localparam int PERIOD = 10;
  localparam int NCH    = 4;
  localparam int GS     = 4;
  localparam int NVEC   = 6;
  // {count[6:0], input gaps, output stalls}
  localparam logic [8:0] VEC [NVEC] = '{
    {7'd16, 1'b0, 1'b0}, {7'd5, 1'b1, 1'b0}, {7'd1, 1'b0, 1'b1},
    {7'd64, 1'b1, 1'b1}, {7'd7, 1'b1, 1'b1}, {7'd4, 1'b0, 1'b1}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_flatten_en = 1'b1;
  logic [6:0] cfg_count = 7'd16;
  logic       in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, done;
  logic [7:0] in_data = '0, out_data;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  chan_group_flattener dut (
    .clk(clk), .rst_n(rst_n), .cfg_flatten_en(cfg_flatten_en), .cfg_count(cfg_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(int e, int k);
    return 8'((k * 37 + e * 11 + 1) % 251 + 1);
  endfunction

  task automatic run_frame(int e, int cnt, bit gap, bit stall);
    int pad = ((cnt + GS - 1) / GS) * GS;
    int total = NCH * pad;
    int kin = 0, nout = 0, cyc = 0;
    bit prev_hold = 0;
    logic [7:0] prev_data = '0;
    @(negedge clk);
    cfg_count = 7'(cnt);
    while (nout < total && cyc < 4000) begin
      @(negedge clk);
      in_valid  = (kin < total) && !(gap && (cyc % 3 == 1));
      in_data   = in_valid ? gen(e, kin) : 8'h00;
      // R4: send nonzero junk at padded positions too (gen is never zero)
      out_ready = !(stall && (cyc % 4 == 2));
      #1;
      if (prev_hold) begin
        chk(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
        chk(out_data == prev_data, "R6 data held", int'(out_data), int'(prev_data));
      end
      if (kin < total) chk(out_valid == 1'b0, "R5 no output during capture", int'(out_valid), 0);
      else             chk(in_ready == 1'b0, "R5 no input during drain", int'(in_ready), 0);
      if (in_valid && in_ready) kin++;
      if (out_valid && out_ready) begin
        int ch = nout / pad;
        int ix = nout % pad;
        int src = (ix / GS) * (GS * NCH) + ch * GS + ix % GS;  // R2 placement
        logic [7:0] exp = (ix >= cnt) ? 8'h00 : gen(e, src);
        chk(out_data == exp, (ix >= cnt) ? "R4 padded zero" : "R3 drain order R2 capture",
            int'(out_data), int'(exp));
        nout++;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      cyc++;
    end
    chk(cyc < 4000, "R9 frame completes", cyc, 4000);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(done == 1'b1, "R7 done pulse", int'(done), 1);
    chk(in_ready == 1'b1, "R7 back in capture", int'(in_ready), 1);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);

    for (int v = 0; v < NVEC; v++)
      run_frame(v, int'(VEC[v][8:2]), VEC[v][1], VEC[v][0]);

    // R8: bypass is combinational and leaves the capture position alone
    @(negedge clk);
    cfg_flatten_en = 1'b0;
    in_valid = 1'b1; in_data = 8'h5A; out_ready = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R8 valid follows", int'(out_valid), 1);
    chk(out_data == 8'h5A, "R8 data follows", int'(out_data), 'h5A);
    chk(in_ready == 1'b0, "R8 ready follows low", int'(in_ready), 0);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R8 ready follows high", int'(in_ready), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_data = 8'(i + 3);
      #1;
      chk(out_data == 8'(i + 3) && done == 1'b0, "R8 bypass stream", int'(out_data), i + 3);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R8 valid drops", int'(out_valid), 0);
    cfg_flatten_en = 1'b1;
    run_frame(9, 9, 1'b0, 1'b0);  // R8: frame after bypass starts from origin

    // R1: reset in the middle of a capture returns to the idle state
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h11;
    repeat (5) @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset mid-frame", int'(out_valid), 0);
    run_frame(3, 12, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule